// File: doc/BRIEF.md
# Interrupt Controller Programming Front End

This block is the register and command-decode front end of an eight-level interrupt controller in the classic two-port style. Software reaches it through a command port and a data port, each with its own write and read strobe. The two ports share one 8-bit write bus and one 8-bit read bus. A command-port write is classified by its bit pattern into an initialization start word or one of two kinds of operation word. Data-port writes either feed the initialization sequence or load the interrupt mask.

The block holds the interrupt mask, the vector base, the single/auto-EOI/special-mask mode flags and the select that chooses which register a command-port read returns. It issues end-of-interrupt requests as a one-cycle pulse to a separate priority and in-service block. It reads that block's request and in-service registers back through the command port. It also turns a level number from that block into the vector byte for the level.

Requests for functions the block does not carry out are accepted. These are level triggering, polling, priority rotation and the 8-bit-processor mode. The unsupported bit alone is ignored, the rest of the word takes effect, and a sticky flag is raised.

Top module: `irqc_prog_if`

## Requirements
- R1: After reset the mask is 0xFF, the vector base is 0, and the single, auto-EOI and special-mask flags are 0. Command-port reads return the request register, the unsupported flag is 0, `eoi_valid` is 0, and `rdata` is 0 while no read strobe is high.
- R2: A data-port write outside the initialization sequence loads the 8-bit mask (1 = masked). A data-port read returns the current mask at any time, including during initialization.
- R3: A command write with bit 4 set starts initialization. It records single mode from bit 1 and "fourth word needed" from bit 0. The next data write sets the vector base to bits 7:3. `ack_vector` equals base*8 + `ack_level`.
- R4: After the base word, one more data write is consumed as the cascade word unless single mode is set. Then the fourth word is consumed only if bit 0 of the start word was set. After the last expected word, data writes load the mask again. Neither consumed word changes the mask.
- R5: In the fourth word, bit 1 loads the auto-EOI flag.
- R6: A command write with bit 4 clear and bit 3 set is a read-control word. If its bit 1 is set, bit 0 selects the source for command-port reads: 1 gives `isr_in`, 0 gives `irr_in`. If bit 1 is clear, the select is unchanged.
- R7: In a read-control word, bit 6 set makes bit 5 load the special-mask flag. With bit 6 clear the flag is unchanged.
- R8: A command write with bits 4 and 3 clear and bit 5 set pulses `eoi_valid` for the one cycle after the write. `eoi_specific` equals bit 6 and `eoi_level` equals bits 2:0. Without bit 5 no pulse is sent.
- R9: The unsupported flag is set by any of these: a start word with bit 3 (level trigger), a read-control word with bit 2 (poll), an EOI-class word with bit 7 (rotate), or a fourth word with bit 0 clear. The flag stays set until reset, and the remaining bits of the word act normally.
- R10: A command write and a data write in the same cycle both take effect. The data write acts on the sequence step held before that cycle, and a start word sets the step for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_rd | input | 1 | Command-port read strobe |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| wdata | input | 8 | Write data, shared by both ports |
| rdata | output | 8 | Read data, 0 when no read strobe |
| irr_in | input | 8 | Request register from the priority block |
| isr_in | input | 8 | In-service register from the priority block |
| ack_level | input | 3 | Level being acknowledged |
| ack_vector | output | 8 | Vector byte for `ack_level` |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 5 | Vector base, upper five bits |
| single_o | output | 1 | Single (no cascade) mode |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt mode |
| special_o | output | 1 | Special mask mode |
| eoi_valid | output | 1 | End-of-interrupt request pulse |
| eoi_specific | output | 1 | Request names a level |
| eoi_level | output | 3 | Level of a specific request |
| unsupported_o | output | 1 | Sticky unsupported-feature flag |

## Verification
Both ports share the write bus, so a command write and a data write in the same cycle see the same byte. The bench provokes this twice. First, a start word is written together with a data write while the data path is loading the mask: the mask must take the byte, and the following data write must land in the vector base. Second, an end-of-interrupt word is written together with a data write: the pulse and the new mask must both appear in the following cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    STEP_MASK = 2'd0,
    STEP_BASE = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } step_e;

  typedef struct packed {
    logic init1;
    logic rdctl;
    logic eoicl;
  } cmd_kind_t;
endpackage

// File: rtl/irqc_cmd_decode.sv
module irqc_cmd_decode
  import irqc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  output cmd_kind_t     kind,
  output logic          unsup
);
  always_comb begin
    kind.init1 = cmd_wr & wdata[4];
    kind.rdctl = cmd_wr & ~wdata[4] & wdata[3];
    kind.eoicl = cmd_wr & ~wdata[4] & ~wdata[3];
    unsup = (kind.init1 & wdata[3]) |
            (kind.rdctl & wdata[2]) |
            (kind.eoicl & wdata[7]);
  end
endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int LVL_W  = 3,
  localparam int BASE_W = DW - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init1,
  input  logic              dat_wr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     mask,
  output logic [BASE_W-1:0] base,
  output logic              single,
  output logic              auto_eoi,
  output logic              unsup
);
  step_e             step_q, step_d;
  logic              single_q, single_d;
  logic              need4_q, need4_d;
  logic              aeoi_q, aeoi_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [DW-1:0]     mask_q, mask_d;

  always_comb begin
    step_d   = step_q;
    single_d = single_q;
    need4_d  = need4_q;
    aeoi_d   = aeoi_q;
    base_d   = base_q;
    mask_d   = mask_q;
    unsup    = 1'b0;
    if (dat_wr) begin
      unique case (step_q)
        STEP_MASK: mask_d = wdata;
        STEP_BASE: begin
          base_d = wdata[DW-1:LVL_W];
          if (!single_q)    step_d = STEP_CASC;
          else if (need4_q) step_d = STEP_MODE;
          else              step_d = STEP_MASK;
        end
        STEP_CASC: step_d = need4_q ? STEP_MODE : STEP_MASK;
        STEP_MODE: begin
          aeoi_d = wdata[1];
          unsup  = ~wdata[0];
          step_d = STEP_MASK;
        end
        default: step_d = STEP_MASK;
      endcase
    end
    if (init1) begin
      single_d = wdata[1];
      need4_d  = wdata[0];
      step_d   = STEP_BASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= STEP_MASK;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
      aeoi_q   <= 1'b0;
      base_q   <= '0;
      mask_q   <= '1;
    end else begin
      step_q   <= step_d;
      single_q <= single_d;
      need4_q  <= need4_d;
      aeoi_q   <= aeoi_d;
      base_q   <= base_d;
      mask_q   <= mask_d;
    end
  end

  assign mask     = mask_q;
  assign base     = base_q;
  assign single   = single_q;
  assign auto_eoi = aeoi_q;
endmodule

// File: rtl/irqc_ocw_regs.sv
module irqc_ocw_regs #(
  parameter int DW    = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdctl,
  input  logic             eoicl,
  input  logic [DW-1:0]    wdata,
  output logic             sel_isr,
  output logic             special,
  output logic             eoi_valid,
  output logic             eoi_specific,
  output logic [LVL_W-1:0] eoi_level
);
  logic             sel_q, sel_d;
  logic             spec_q, spec_d;
  logic             ev_q, ev_d;
  logic             es_q, es_d;
  logic [LVL_W-1:0] el_q, el_d;

  always_comb begin
    sel_d  = sel_q;
    spec_d = spec_q;
    ev_d   = 1'b0;
    es_d   = es_q;
    el_d   = el_q;
    if (rdctl && wdata[1]) sel_d  = wdata[0];
    if (rdctl && wdata[6]) spec_d = wdata[5];
    if (eoicl && wdata[5]) begin
      ev_d = 1'b1;
      es_d = wdata[6];
      el_d = wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      spec_q <= 1'b0;
      ev_q   <= 1'b0;
      es_q   <= 1'b0;
      el_q   <= '0;
    end else begin
      sel_q  <= sel_d;
      spec_q <= spec_d;
      ev_q   <= ev_d;
      es_q   <= es_d;
      el_q   <= el_d;
    end
  end

  assign sel_isr      = sel_q;
  assign special      = spec_q;
  assign eoi_valid    = ev_q;
  assign eoi_specific = es_q;
  assign eoi_level    = el_q;
endmodule

// File: rtl/irqc_prog_if.sv
module irqc_prog_if
  import irqc_pkg::*;
#(
  parameter int N_LVL = 8,
  localparam int DW     = N_LVL,
  localparam int LVL_W  = $clog2(N_LVL),
  localparam int BASE_W = DW - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_rd,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     irr_in,
  input  logic [DW-1:0]     isr_in,
  input  logic [LVL_W-1:0]  ack_level,
  output logic [DW-1:0]     ack_vector,
  output logic [DW-1:0]     mask_o,
  output logic [BASE_W-1:0] vec_base_o,
  output logic              single_o,
  output logic              auto_eoi_o,
  output logic              special_o,
  output logic              eoi_valid,
  output logic              eoi_specific,
  output logic [LVL_W-1:0]  eoi_level,
  output logic              unsupported_o
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  cmd_kind_t  kind;
  logic       unsup_cmd, unsup_mode;
  logic       sel_isr;
  logic       unsup_q, unsup_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  irqc_cmd_decode #(.DW(DW)) u_dec (
    .cmd_wr (cmd_wr),
    .wdata  (wdata),
    .kind   (kind),
    .unsup  (unsup_cmd)
  );

  irqc_init_seq #(.DW(DW), .LVL_W(LVL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .init1    (kind.init1),
    .dat_wr   (dat_wr),
    .wdata    (wdata),
    .mask     (mask_o),
    .base     (vec_base_o),
    .single   (single_o),
    .auto_eoi (auto_eoi_o),
    .unsup    (unsup_mode)
  );

  irqc_ocw_regs #(.DW(DW), .LVL_W(LVL_W)) u_ocw (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .rdctl        (kind.rdctl),
    .eoicl        (kind.eoicl),
    .wdata        (wdata),
    .sel_isr      (sel_isr),
    .special      (special_o),
    .eoi_valid    (eoi_valid),
    .eoi_specific (eoi_specific),
    .eoi_level    (eoi_level)
  );

  always_comb unsup_d = unsup_q | unsup_cmd | unsup_mode;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) unsup_q <= 1'b0;
    else            unsup_q <= unsup_d;
  end
  assign unsupported_o = unsup_q;

  always_comb begin
    if (dat_rd)      rdata = mask_o;
    else if (cmd_rd) rdata = sel_isr ? isr_in : irr_in;
    else             rdata = '0;
  end

  assign ack_vector = {vec_base_o, ack_level};
endmodule

// File: rtl/irqc_prog_if_chk.sv
module irqc_prog_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       dat_wr,
  input logic [7:0] wdata,
  input logic [7:0] mask_o,
  input logic [4:0] vec_base_o,
  input logic       auto_eoi_o,
  input logic       special_o,
  input logic       eoi_valid,
  input logic       unsupported_o
);
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(mask_o));

  a_r3_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(vec_base_o));

  a_r5_aeoi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(auto_eoi_o));

  a_r7_special_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(special_o));

  a_r8_eoi_source: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> ($past(cmd_wr) && $past(wdata[5]) && !$past(wdata[4]) && !$past(wdata[3])));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported_o |=> unsupported_o);
endmodule

bind irqc_prog_if irqc_prog_if_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_wr        (cmd_wr),
  .dat_wr        (dat_wr),
  .wdata         (wdata),
  .mask_o        (mask_o),
  .vec_base_o    (vec_base_o),
  .auto_eoi_o    (auto_eoi_o),
  .special_o     (special_o),
  .eoi_valid     (eoi_valid),
  .unsupported_o (unsupported_o)
);

// File: tb/test_irqc_prog_if.sv
module test_irqc_prog_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0, cmd_rd = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irr_in = 8'h3C;
  logic [7:0] isr_in = 8'h81;
  logic [2:0] ack_level = 3'd0;
  logic [7:0] ack_vector, mask_o;
  logic [4:0] vec_base_o;
  logic       single_o, auto_eoi_o, special_o;
  logic       eoi_valid, eoi_specific;
  logic [2:0] eoi_level;
  logic       unsupported_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  irqc_prog_if i_irqc_prog_if (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .wdata(wdata), .rdata(rdata),
    .irr_in(irr_in), .isr_in(isr_in), .ack_level(ack_level),
    .ack_vector(ack_vector), .mask_o(mask_o), .vec_base_o(vec_base_o),
    .single_o(single_o), .auto_eoi_o(auto_eoi_o), .special_o(special_o),
    .eoi_valid(eoi_valid), .eoi_specific(eoi_specific),
    .eoi_level(eoi_level), .unsupported_o(unsupported_o)
  );

  localparam logic [1:0] CW = 2'd0, DWR = 2'd1, CR = 2'd2, DR = 2'd3;
  localparam int NV = 31;
  // {op, requirement number, write data, expected read data}
  localparam logic [21:0] VEC [NV] = '{
    {DR,  4'd1,  8'h00, 8'hFF},  // R1 mask after reset
    {CR,  4'd1,  8'h00, 8'h3C},  // R1 default read select = request
    {DWR, 4'd2,  8'h5A, 8'h00},  // R2 load mask
    {DR,  4'd2,  8'h00, 8'h5A},
    {CW,  4'd3,  8'h13, 8'h00},  // R3 start: single, fourth word
    {DWR, 4'd3,  8'h47, 8'h00},  // base word
    {DWR, 4'd5,  8'h03, 8'h00},  // R5 fourth word, auto-EOI
    {DWR, 4'd4,  8'h0F, 8'h00},  // R4 back to mask
    {DR,  4'd4,  8'h00, 8'h0F},
    {CW,  4'd4,  8'h11, 8'h00},  // R4 cascade, fourth word
    {DWR, 4'd4,  8'h20, 8'h00},
    {DWR, 4'd4,  8'h04, 8'h00},  // cascade word
    {DR,  4'd4,  8'h00, 8'h0F},  // mask untouched
    {DWR, 4'd4,  8'h01, 8'h00},  // fourth word, auto-EOI off
    {DWR, 4'd4,  8'hA5, 8'h00},
    {DR,  4'd4,  8'h00, 8'hA5},
    {CW,  4'd4,  8'h10, 8'h00},  // R4 cascade, no fourth word
    {DWR, 4'd4,  8'h88, 8'h00},
    {DWR, 4'd4,  8'h77, 8'h00},
    {DWR, 4'd4,  8'h33, 8'h00},
    {DR,  4'd4,  8'h00, 8'h33},
    {CW,  4'd6,  8'h0B, 8'h00},  // R6 select in-service
    {CR,  4'd6,  8'h00, 8'h81},
    {CW,  4'd6,  8'h08, 8'h00},  // bit1 clear: select kept
    {CR,  4'd6,  8'h00, 8'h81},
    {CW,  4'd6,  8'h0A, 8'h00},  // select request
    {CR,  4'd6,  8'h00, 8'h3C},
    {CW,  4'd2,  8'h12, 8'h00},  // R2 read mask mid-sequence
    {DR,  4'd2,  8'h00, 8'h33},
    {DWR, 4'd2,  8'h98, 8'h00},
    {DR,  4'd2,  8'h00, 8'h33}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    wdata  = d;
    cmd_wr = (op == CW);
    dat_wr = (op == DWR);
    cmd_rd = (op == CR);
    dat_rd = (op == DR);
    #2 r = rdata;
    @(posedge clk);
    #1;
    cmd_wr = 1'b0; dat_wr = 1'b0; cmd_rd = 1'b0; dat_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    #2;
    chk("R1 mask", mask_o, 8'hFF);
    chk("R1 base", {3'b0, vec_base_o}, 8'h00);
    chk("R1 flags", {4'b0, single_o, auto_eoi_o, special_o, unsupported_o}, 8'h00);
    chk("R1 eoi_valid", {7'b0, eoi_valid}, 8'h00);
    chk("R1 rdata idle", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][21:20], VEC[i][15:8], rd);
      if (VEC[i][21:20] == CR || VEC[i][21:20] == DR)
        chk($sformatf("R%0d vector %0d", VEC[i][19:16], i), rd, VEC[i][7:0]);
    end

    // R3 base from 0x98, vector of level 5
    ack_level = 3'd5;
    #1;
    chk("R3 ack_vector", ack_vector, 8'h9D);
    chk("R3 single", {7'b0, single_o}, 8'h01);
    chk("R5 auto-EOI cleared", {7'b0, auto_eoi_o}, 8'h00);
    chk("R9 no flag yet", {7'b0, unsupported_o}, 8'h00);

    // R7 special mask
    do_op(CW, 8'h68, rd);
    chk("R7 special set", {7'b0, special_o}, 8'h01);
    do_op(CW, 8'h28, rd);
    chk("R7 special kept", {7'b0, special_o}, 8'h01);
    do_op(CW, 8'h48, rd);
    chk("R7 special cleared", {7'b0, special_o}, 8'h00);

    // R8 end-of-interrupt
    do_op(CW, 8'h20, rd);
    chk("R8 nonspecific", {6'b0, eoi_valid, eoi_specific}, 8'h02);
    @(posedge clk); #1;
    chk("R8 pulse ends", {7'b0, eoi_valid}, 8'h00);
    do_op(CW, 8'h65, rd);
    chk("R8 specific", {4'b0, eoi_valid, eoi_specific, eoi_level[1:0]}, 8'h0D);
    chk("R8 level", {5'b0, eoi_level}, 8'h05);
    do_op(CW, 8'h40, rd);
    chk("R8 no eoi bit", {7'b0, eoi_valid}, 8'h00);

    // R10 same-cycle command and data writes
    do_reset();
    @(negedge clk);
    wdata = 8'h13; cmd_wr = 1'b1; dat_wr = 1'b1;
    @(posedge clk); #1; cmd_wr = 1'b0; dat_wr = 1'b0;
    chk("R10 mask from shared write", mask_o, 8'h13);
    do_op(DWR, 8'hF0, rd);
    chk("R10 next data is base", {3'b0, vec_base_o}, 8'h1E);
    chk("R10 mask kept", mask_o, 8'h13);
    do_op(DWR, 8'h03, rd);
    chk("R5 auto-EOI set", {7'b0, auto_eoi_o}, 8'h01);
    @(negedge clk);
    wdata = 8'h20; cmd_wr = 1'b1; dat_wr = 1'b1;
    @(posedge clk); #1; cmd_wr = 1'b0; dat_wr = 1'b0;
    chk("R10 eoi with mask", {7'b0, eoi_valid}, 8'h01);
    chk("R10 mask with eoi", mask_o, 8'h20);

    // R9 unsupported requests
    do_op(CW, 8'h0C, rd);
    chk("R9 poll flag", {7'b0, unsupported_o}, 8'h01);
    do_op(DWR, 8'h44, rd);
    chk("R9 sticky", {7'b0, unsupported_o}, 8'h01);
    do_reset();
    do_op(CW, 8'hA0, rd);
    chk("R9 rotate eoi still sent", {6'b0, eoi_valid, unsupported_o}, 8'h03);
    do_reset();
    do_op(CW, 8'h18, rd);
    chk("R9 level flag", {7'b0, unsupported_o}, 8'h01);
    do_op(DWR, 8'h10, rd);
    chk("R9 sequence runs", {3'b0, vec_base_o}, 8'h02);
    chk("R9 mask intact", mask_o, 8'hFF);
    do_reset();
    do_op(CW, 8'h13, rd);
    do_op(DWR, 8'h00, rd);
    do_op(DWR, 8'h02, rd);
    chk("R9 mode-word flag", {6'b0, auto_eoi_o, unsupported_o}, 8'h03);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule